// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer that lives across two clocks. Software reaches it through a simple register port on the bus clock. The timing itself runs on a slow functional clock. There an up-counter advances, either on every functional-clock edge or through a power-of-two prescaler. When the counter rolls over from all ones while the timer is armed, the block pulses a reset output and latches a sticky reset-cause flag.

Arming and disarming each take a two-word keyed sequence written to a key register. Software keeps the watchdog alive by writing the trigger register with a value that differs from the previous trigger value, which reloads the counter from the load register. Every configuration write is posted into the functional domain. A per-register pending bit stays set until the write has taken effect, and software polls it before writing that register again. The counter value is carried back to the bus domain by a handshake, so it can be read.

Top module: `wdt_keyed_timer`

## Requirements
- R1: After reset, all pending bits read 0, the counter and load values read 0, the cause flag reads 0, `wdt_rst` is low, the timer is disarmed (the counter does not move), and the stored last trigger value is 0.
- R2: The timer arms only when the key register (address 4, compared on its low 16 bits) receives 0xBBBB and then 0x4444 as consecutive accepted key writes. Once armed, the counter advances.
- R3: The timer disarms only when the key register receives 0xAAAA and then 0x5555 as consecutive accepted key writes. Once disarmed, the counter holds its value.
- R4: Any other key value written between the two words abandons the sequence. A second word written without its first word has no effect.
- R5: A trigger write (address 3) reloads the counter from the load register only when the written value differs from the last stored trigger value. Writing the same value again leaves the counter unchanged.
- R6: Control register (address 0) bit 5 enables the prescaler, and bits 4:2 give a ratio n. With the prescaler enabled the counter advances once every 2^n functional clocks. With it disabled the counter advances on every functional clock, whatever the ratio field holds.
- R7: A write to address i (0 control, 1 counter, 2 load, 3 trigger, 4 key) sets pending bit i of the status register (address 5). That bit clears by itself once the write has taken effect in the functional domain. A write to a register whose pending bit is set is dropped.
- R8: A counter write (address 1) sets the counter to the written value. Reading address 1 returns the counter value after it has been synchronised to the bus clock.
- R9: When the counter advances from all ones while armed, it reloads from the load register, `wdt_rst` goes high for exactly one bus-clock cycle, and the cause flag becomes 1.
- R10: Writing 1 to bit 0 of address 6 clears the cause flag. If an overflow reaches the bus domain in the same cycle, the set wins and the flag stays 1.
- R11: Reading addresses 0, 2, 3 and 4 returns the last accepted write to that register. Address 6 returns the cause flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus / register clock |
| clk_fn | input | 1 | Slow functional clock for prescaler and counter |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for `bus_addr`, combinational |
| wdt_rst | output | 1 | Watchdog reset pulse, one bus-clock cycle |

## Verification
Two events can land on the same bus-clock edge: a cause-clear write from software and an overflow event arriving from the functional domain. The bench provokes the collision by loading a value close to all ones, arming the timer, and then holding a clear write on every bus cycle until the reset pulse appears. It judges the outcome at the negative edge of the pulse cycle, where the flag must read 1. One cycle later, with the clear still held, the flag must read 0.

// File: rtl/wdt_kt_pkg.sv
package wdt_kt_pkg;

   // register word addresses; posted registers use their address as pending-bit index
   localparam logic [2:0] A_CTRL  = 3'd0;
   localparam logic [2:0] A_CNT   = 3'd1;
   localparam logic [2:0] A_LOAD  = 3'd2;
   localparam logic [2:0] A_TRIG  = 3'd3;
   localparam logic [2:0] A_KEY   = 3'd4;
   localparam logic [2:0] A_PEND  = 3'd5;
   localparam logic [2:0] A_CAUSE = 3'd6;

   localparam int NCHAN = 5;
   localparam int KEY_W = 16;

   localparam logic [KEY_W-1:0] KEY_ARM_A = 16'hBBBB;
   localparam logic [KEY_W-1:0] KEY_ARM_B = 16'h4444;
   localparam logic [KEY_W-1:0] KEY_DIS_A = 16'hAAAA;
   localparam logic [KEY_W-1:0] KEY_DIS_B = 16'h5555;

   localparam int CTRL_PRE_EN = 5;
   localparam int CTRL_RATIO_LSB = 2;

   typedef enum logic [1:0] {
      K_IDLE,
      K_ARM1,
      K_DIS1
   } key_st_e;

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("wdt_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_st
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= 1'b0;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wdt_post_chan.sv
module wdt_post_chan #(
   parameter int DW   = 32,
   parameter int SYNC = 2
) (
   input  logic          clk_bus,
   input  logic          clk_fn,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] shadow,
   output logic          pend,
   output logic          apply
);
   logic req_b, ack_s;
   logic req_f, req_fd;

   // bus side: accept only when nothing is in flight
   always_ff @(posedge clk_bus or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
         req_b  <= 1'b0;
      end else if (wr_en && !pend) begin
         shadow <= wdata;
         req_b  <= ~req_b;
      end
   end

   assign pend = req_b ^ ack_s;

   wdt_sync #(.STAGES(SYNC)) u_req_s (.clk(clk_fn), .rst_n(rst_n), .d(req_b), .q(req_f));

   always_ff @(posedge clk_fn or negedge rst_n)
      if (!rst_n) req_fd <= 1'b0;
      else        req_fd <= req_f;

   assign apply = req_f ^ req_fd;

   wdt_sync #(.STAGES(SYNC)) u_ack_s (.clk(clk_bus), .rst_n(rst_n), .d(req_fd), .q(ack_s));
endmodule

// File: rtl/wdt_cnt_mirror.sv
module wdt_cnt_mirror #(
   parameter int CW   = 32,
   parameter int SYNC = 2
) (
   input  logic          clk_fn,
   input  logic          clk_bus,
   input  logic          rst_n,
   input  logic [CW-1:0] cnt_fn,
   output logic [CW-1:0] cnt_bus
);
   logic [CW-1:0] snap;
   logic req_f, ack_f, req_b, ack_b;

   wdt_sync #(.STAGES(SYNC)) u_ack_s (.clk(clk_fn), .rst_n(rst_n), .d(ack_b), .q(ack_f));

   always_ff @(posedge clk_fn or negedge rst_n) begin
      if (!rst_n) begin
         snap  <= '0;
         req_f <= 1'b0;
      end else if (ack_f == req_f) begin
         snap  <= cnt_fn;
         req_f <= ~req_f;
      end
   end

   wdt_sync #(.STAGES(SYNC)) u_req_s (.clk(clk_bus), .rst_n(rst_n), .d(req_f), .q(req_b));

   always_ff @(posedge clk_bus or negedge rst_n) begin
      if (!rst_n) begin
         cnt_bus <= '0;
         ack_b   <= 1'b0;
      end else if (req_b != ack_b) begin
         cnt_bus <= snap;
         ack_b   <= req_b;
      end
   end
endmodule

// File: rtl/wdt_tick_core.sv
module wdt_tick_core
   import wdt_kt_pkg::*;
#(
   parameter int DW      = 32,
   parameter int CW      = 32,
   parameter int RATIO_W = 3
) (
   input  logic             clk_fn,
   input  logic             rst_n,
   input  logic [NCHAN-1:0] apply,
   input  logic [DW-1:0]    ctrl_d,
   input  logic [DW-1:0]    cnt_d,
   input  logic [DW-1:0]    load_d,
   input  logic [DW-1:0]    trig_d,
   input  logic [DW-1:0]    key_d,
   output logic [CW-1:0]    cnt,
   output logic             ovf_tgl
);
   localparam int PCW = (1 << RATIO_W) - 1;

   logic               pre_en, armed, tick;
   logic [RATIO_W-1:0] ratio;
   logic [PCW-1:0]     pre_cnt;
   logic [PCW:0]       lim_w;
   logic [CW-1:0]      load_q;
   logic [DW-1:0]      last_trig;
   logic [KEY_W-1:0]   kv;
   key_st_e            kst;

   assign lim_w = ({{PCW{1'b0}}, 1'b1} << ratio) - 1'b1;
   assign tick  = pre_en ? (pre_cnt == lim_w[PCW-1:0]) : 1'b1;
   assign kv    = key_d[KEY_W-1:0];

   // configuration and prescaler
   always_ff @(posedge clk_fn or negedge rst_n) begin
      if (!rst_n) begin
         pre_en  <= 1'b0;
         ratio   <= '0;
         pre_cnt <= '0;
         load_q  <= '0;
      end else begin
         if (apply[A_CTRL]) begin
            pre_en <= ctrl_d[CTRL_PRE_EN];
            ratio  <= ctrl_d[CTRL_RATIO_LSB +: RATIO_W];
         end
         if (apply[A_LOAD]) load_q <= load_d[CW-1:0];
         if (!armed || apply[A_CTRL] || tick) pre_cnt <= '0;
         else                                  pre_cnt <= pre_cnt + 1'b1;
      end
   end

   // keyed arm / disarm sequencer
   always_ff @(posedge clk_fn or negedge rst_n) begin
      if (!rst_n) begin
         kst   <= K_IDLE;
         armed <= 1'b0;
      end else if (apply[A_KEY]) begin
         if (kv == KEY_ARM_A)                        kst <= K_ARM1;
         else if (kv == KEY_DIS_A)                   kst <= K_DIS1;
         else if (kv == KEY_ARM_B && kst == K_ARM1) begin
            armed <= 1'b1;
            kst   <= K_IDLE;
         end else if (kv == KEY_DIS_B && kst == K_DIS1) begin
            armed <= 1'b0;
            kst   <= K_IDLE;
         end else                                    kst <= K_IDLE;
      end
   end

   // counter: direct write beats trigger reload beats counting
   always_ff @(posedge clk_fn or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         ovf_tgl   <= 1'b0;
         last_trig <= '0;
      end else begin
         if (apply[A_TRIG]) last_trig <= trig_d;
         if (apply[A_CNT])
            cnt <= cnt_d[CW-1:0];
         else if (apply[A_TRIG] && trig_d != last_trig)
            cnt <= load_q;
         else if (armed && tick) begin
            if (&cnt) begin
               cnt     <= load_q;
               ovf_tgl <= ~ovf_tgl;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/wdt_keyed_timer.sv
module wdt_keyed_timer
   import wdt_kt_pkg::*;
#(
   parameter int DW      = 32,
   parameter int CW      = 32,
   parameter int SYNC    = 2,
   parameter int RATIO_W = 3
) (
   input  logic          clk_bus,
   input  logic          clk_fn,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [2:0]    bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          wdt_rst
);
   logic [NCHAN-1:0] pend, apply;
   logic [DW-1:0]    shadow [NCHAN];
   logic [CW-1:0]    cnt_fn, cnt_bus;
   logic             ovf_tgl, ovf_s, ovf_d, ovf_evt, cause, cause_clr;

   generate
      if (DW < KEY_W || CW > DW || CW < 8) begin : g_bad_w
         $error("wdt_keyed_timer: need KEY_W <= DW, 8 <= CW <= DW");
      end
      if (SYNC < 2) begin : g_bad_s
         $error("wdt_keyed_timer: SYNC must be at least 2");
      end
      if (RATIO_W < 1 || RATIO_W > 4 || CTRL_RATIO_LSB + RATIO_W > CTRL_PRE_EN) begin : g_bad_r
         $error("wdt_keyed_timer: RATIO_W out of range");
      end
      for (genvar i = 0; i < NCHAN; i++) begin : g_chan
         wdt_post_chan #(.DW(DW), .SYNC(SYNC)) u_chan (
            .clk_bus (clk_bus),
            .clk_fn  (clk_fn),
            .rst_n   (rst_n),
            .wr_en   (bus_wr && bus_addr == 3'(i)),
            .wdata   (bus_wdata),
            .shadow  (shadow[i]),
            .pend    (pend[i]),
            .apply   (apply[i])
         );
      end
   endgenerate

   wdt_tick_core #(.DW(DW), .CW(CW), .RATIO_W(RATIO_W)) u_core (
      .clk_fn  (clk_fn),
      .rst_n   (rst_n),
      .apply   (apply),
      .ctrl_d  (shadow[A_CTRL]),
      .cnt_d   (shadow[A_CNT]),
      .load_d  (shadow[A_LOAD]),
      .trig_d  (shadow[A_TRIG]),
      .key_d   (shadow[A_KEY]),
      .cnt     (cnt_fn),
      .ovf_tgl (ovf_tgl)
   );

   wdt_cnt_mirror #(.CW(CW), .SYNC(SYNC)) u_mirror (
      .clk_fn  (clk_fn),
      .clk_bus (clk_bus),
      .rst_n   (rst_n),
      .cnt_fn  (cnt_fn),
      .cnt_bus (cnt_bus)
   );

   wdt_sync #(.STAGES(SYNC)) u_ovf_s (.clk(clk_bus), .rst_n(rst_n), .d(ovf_tgl), .q(ovf_s));

   assign ovf_evt   = ovf_s ^ ovf_d;
   assign cause_clr = bus_wr && bus_addr == A_CAUSE && bus_wdata[0];

   // overflow event sets cause with priority over a clear in the same cycle
   always_ff @(posedge clk_bus or negedge rst_n) begin
      if (!rst_n) begin
         ovf_d   <= 1'b0;
         wdt_rst <= 1'b0;
         cause   <= 1'b0;
      end else begin
         ovf_d   <= ovf_s;
         wdt_rst <= ovf_evt;
         if (ovf_evt)        cause <= 1'b1;
         else if (cause_clr) cause <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL:  bus_rdata = shadow[A_CTRL];
         A_CNT:   bus_rdata = DW'(cnt_bus);
         A_LOAD:  bus_rdata = shadow[A_LOAD];
         A_TRIG:  bus_rdata = shadow[A_TRIG];
         A_KEY:   bus_rdata = shadow[A_KEY];
         A_PEND:  bus_rdata = DW'(pend);
         A_CAUSE: bus_rdata = DW'(cause);
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdt_keyed_timer_chk.sv
module wdt_keyed_timer_chk
   import wdt_kt_pkg::*;
#(
   parameter int DW = 32
) (
   input logic          clk_bus,
   input logic          rst_n,
   input logic          bus_wr,
   input logic [2:0]    bus_addr,
   input logic [DW-1:0] bus_wdata,
   input logic          wdt_rst,
   input logic          cause,
   input logic [NCHAN-1:0] pend,
   input logic [DW-1:0] load_sh
);
   // R7
   load_pend_src_chk: assert property (@(posedge clk_bus) disable iff (!rst_n)
      $rose(pend[A_LOAD]) |-> $past(bus_wr && bus_addr == A_LOAD));

   // R7
   key_pend_src_chk: assert property (@(posedge clk_bus) disable iff (!rst_n)
      $rose(pend[A_KEY]) |-> $past(bus_wr && bus_addr == A_KEY));

   // R7
   load_drop_chk: assert property (@(posedge clk_bus) disable iff (!rst_n)
      (pend[A_LOAD] && bus_wr && bus_addr == A_LOAD) |=> $stable(load_sh));

   // R9
   rst_single_chk: assert property (@(posedge clk_bus) disable iff (!rst_n)
      wdt_rst |=> !wdt_rst);

   // R9
   cause_rise_chk: assert property (@(posedge clk_bus) disable iff (!rst_n)
      $rose(cause) |-> wdt_rst);

   // R10
   cause_set_wins_chk: assert property (@(posedge clk_bus) disable iff (!rst_n)
      wdt_rst |-> cause);

   // R10
   cause_clear_chk: assert property (@(posedge clk_bus) disable iff (!rst_n)
      (bus_wr && bus_addr == A_CAUSE && bus_wdata[0]) |=> (!cause || wdt_rst));
endmodule

bind wdt_keyed_timer wdt_keyed_timer_chk #(.DW(DW)) u_chk (
   .clk_bus   (clk_bus),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .wdt_rst   (wdt_rst),
   .cause     (cause),
   .pend      (pend),
   .load_sh   (shadow[2])
);

// File: tb/test_wdt_keyed_timer.sv
module test_wdt_keyed_timer;
   logic        clk_bus = 1'b0, clk_fn = 1'b0, rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        wdt_rst;

   int n_tests = 0, n_fail = 0, cyc = 0;
   logic [31:0] trig_last = '0;

   localparam int FN_BUS = 8; // bus cycles per functional clock, rounded up

   always #10 clk_bus = ~clk_bus;   // 50 MHz
   always #73 clk_fn  = ~clk_fn;    // unrelated slow clock

   wdt_keyed_timer i_wdt_keyed_timer (
      .clk_bus(clk_bus), .clk_fn(clk_fn), .rst_n(rst_n), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst(wdt_rst)
   );

   always @(posedge clk_bus) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: run hung, act=%0d exp<150000 cycles", cyc);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input logic [31:0] act, input logic [31:0] lo, input logic [31:0] hi);
      n_tests++;
      if (act < lo || act > hi) begin
         n_fail++;
         $display("FAIL %s: act=%h exp=%h..%h", req, act, lo, hi);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk_bus);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk_bus);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk_bus);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] p;
      for (int i = 0; i < 2000; i++) begin
         rd(3'd5, p);
         if (p[4:0] == 5'd0) break;
      end
   endtask

   // posted write, wait until applied, then let the counter mirror catch up
   task automatic wr_settle(input logic [2:0] a, input logic [31:0] d);
      wr(a, d);
      wait_idle();
      repeat (16 * FN_BUS) @(negedge clk_bus);
   endtask

   task automatic trigger();
      trig_last = ~trig_last;
      wr_settle(3'd3, trig_last);
   endtask

   task automatic key_pair(input logic [15:0] k1, input logic [15:0] k2);
      wr_settle(3'd4, {16'h0, k1});
      wr_settle(3'd4, {16'h0, k2});
   endtask

   task automatic t_reset();
      logic [31:0] v, c0;
      rd(3'd5, v); chk("R1 pending after reset", v, 32'h0);
      rd(3'd6, v); chk("R1 cause after reset", v, 32'h0);
      rd(3'd2, v); chk("R1 load after reset", v, 32'h0);
      chk("R1 wdt_rst after reset", {31'h0, wdt_rst}, 32'h0);
      rd(3'd1, c0);
      repeat (40 * FN_BUS) @(negedge clk_bus);
      rd(3'd1, v); chk("R1 counter idle after reset", v, 32'h0);
   endtask

   task automatic t_abandon();
      logic [31:0] v;
      wr_settle(3'd4, 32'h4444);
      repeat (40 * FN_BUS) @(negedge clk_bus);
      rd(3'd1, v); chk("R4 lone second word ignored", v, 32'h0);
      wr_settle(3'd4, 32'hBBBB);
      wr_settle(3'd4, 32'h1111);
      wr_settle(3'd4, 32'h4444);
      repeat (40 * FN_BUS) @(negedge clk_bus);
      rd(3'd1, v); chk("R4 interrupted arm ignored", v, 32'h0);
   endtask

   task automatic t_cnt_write();
      logic [31:0] v;
      wr_settle(3'd1, 32'h00AB_CDEF);
      rd(3'd1, v); chk("R8 counter write readback", v, 32'h00AB_CDEF);
   endtask

   task automatic t_trigger();
      logic [31:0] v;
      wr_settle(3'd2, 32'h0000_0100);
      rd(3'd2, v); chk("R11 load readback", v, 32'h0000_0100);
      trigger();
      rd(3'd1, v); chk("R5 trigger reloads", v, 32'h0000_0100);
      rd(3'd3, v); chk("R11 trigger readback", v, trig_last);
      wr_settle(3'd1, 32'h0000_0500);
      wr_settle(3'd3, trig_last);
      rd(3'd1, v); chk("R5 same trigger value ignored", v, 32'h0000_0500);
      trigger();
      rd(3'd1, v); chk("R5 complement trigger reloads", v, 32'h0000_0100);
   endtask

   task automatic t_pending();
      logic [31:0] v;
      wr(3'd2, 32'h0000_0222);
      rd(3'd5, v); chk("R7 load pending bit2", v & 32'h1F, 32'h4);
      wr(3'd2, 32'h0000_0333);
      wait_idle();
      rd(3'd5, v); chk("R7 pending clears", v, 32'h0);
      rd(3'd2, v); chk("R7 write while pending dropped", v, 32'h0000_0222);
      wr(3'd0, 32'h0);
      rd(3'd5, v); chk("R7 control pending bit0", v & 32'h1F, 32'h1);
      wait_idle();
      wr(3'd3, ~trig_last);
      trig_last = ~trig_last;
      rd(3'd5, v); chk("R7 trigger pending bit3", v & 32'h1F, 32'h8);
      wait_idle();
      repeat (16 * FN_BUS) @(negedge clk_bus);
      rd(3'd1, v); chk("R7 dropped load not used", v, 32'h0000_0222);
      wr(3'd4, 32'h1234);
      rd(3'd5, v); chk("R7 key pending bit4", v & 32'h1F, 32'h10);
      wait_idle();
   endtask

   task automatic t_arm_disarm();
      logic [31:0] v, c0, c1;
      wr_settle(3'd2, 32'h0);
      trigger();
      key_pair(16'hBBBB, 16'h4444);
      rd(3'd4, v); chk("R11 key readback", v, 32'h4444);
      rd(3'd1, c0);
      repeat (50 * FN_BUS) @(negedge clk_bus);
      rd(3'd1, c1);
      chk_rng("R2 armed counter advances", c1 - c0, 32'd30, 32'd60);
      key_pair(16'hAAAA, 16'h5555);
      rd(3'd1, c0);
      repeat (50 * FN_BUS) @(negedge clk_bus);
      rd(3'd1, c1);
      chk("R3 disarmed counter holds", c1, c0);
   endtask

   // 800 functional clocks = 800*146 ns = 5840 bus cycles
   task automatic rate(input logic [31:0] ctrl, input logic [31:0] lo, input logic [31:0] hi, input string req);
      logic [31:0] c0, c1;
      wr_settle(3'd0, ctrl);
      wr_settle(3'd1, 32'h0);
      wr(3'd4, 32'hBBBB); wait_idle();
      wr(3'd4, 32'h4444); wait_idle();
      repeat (16 * FN_BUS) @(negedge clk_bus);
      rd(3'd1, c0);
      repeat (5840) @(negedge clk_bus);
      rd(3'd1, c1);
      chk_rng(req, c1 - c0, lo, hi);
      key_pair(16'hAAAA, 16'h5555);
   endtask

   task automatic t_prescale();
      rate(32'h0000_002C, 32'd94, 32'd106, "R6 prescale by 8");
      rate(32'h0000_000C, 32'd788, 32'd812, "R6 prescaler off ignores ratio");
      rate(32'h0000_0024, 32'd394, 32'd406, "R6 prescale by 2");
   endtask

   task automatic t_overflow();
      logic [31:0] v;
      bit seen;
      wr_settle(3'd0, 32'h0);
      wr_settle(3'd2, 32'hFFFF_FFF0);
      trigger();
      wr(3'd4, 32'hBBBB); wait_idle();
      wr(3'd4, 32'h4444); wait_idle();
      seen = 0;
      bus_addr = 3'd6;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk_bus);
         if (wdt_rst) begin seen = 1; break; end
      end
      chk("R9 reset pulse seen", {31'h0, seen}, 32'h1);
      #1 chk("R9 cause set with pulse", bus_rdata, 32'h1);
      @(negedge clk_bus);
      chk("R9 pulse one cycle wide", {31'h0, wdt_rst}, 32'h0);
      rd(3'd1, v); chk_rng("R9 counter reloads from load", v, 32'hFFFF_FFF0, 32'hFFFF_FFFF);
      wr(3'd6, 32'h1);
      bus_addr = 3'd6;
      #1 chk("R10 cause cleared", {31'h0, bus_rdata[0] & ~wdt_rst}, 32'h0);
      // hold a clear on every cycle until the next overflow arrives
      @(negedge clk_bus);
      bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 32'h1;
      seen = 0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk_bus);
         if (wdt_rst) begin seen = 1; break; end
      end
      chk("R10 pulse under clear", {31'h0, seen}, 32'h1);
      #1 chk("R10 set wins over clear", bus_rdata, 32'h1);
      @(negedge clk_bus);
      #1 chk("R10 clear next cycle", bus_rdata, 32'h0);
      bus_wr = 1'b0;
      key_pair(16'hAAAA, 16'h5555);
   endtask

   initial begin
      repeat (5) @(negedge clk_bus);
      rst_n = 1'b1;
      repeat (5) @(negedge clk_bus);
      t_reset();
      t_abandon();
      t_cnt_write();
      t_trigger();
      t_pending();
      t_arm_disarm();
      t_prescale();
      t_overflow();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule